// File: doc/BRIEF.md
# Four-Source Interrupt State, Enable and Test Bank

This block collects single-cycle event pulses from four peripheral sources and turns them into four level-sensitive interrupt lines, one per source. Each pulse sets a sticky pending bit. Software clears pending bits by writing ones, masks them through an enable register, and can force pending bits through a write-only test register so that interrupt routing can be checked without real traffic.

Software reaches the bank over a simple 32-bit register port. The port has a write strobe, a two-bit word address, write data and combinational read data. The same bit position is used in all three registers: bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty and bit 3 is RX overflow. Word address 0 is the pending register, 1 is the enable register, 2 is the test register, and 3 is unused.

Top module: `irq_evt_bank`

## Requirements
- R1: After reset, the pending register, the enable register and all four interrupt outputs are zero.
- R2: A one on `evt_in[i]` in a cycle sets pending bit i. The bit map is bit0 TX watermark, bit1 RX watermark, bit2 TX empty, bit3 RX overflow.
- R3: A write to address 0 clears each pending bit whose write-data bit is one and leaves every other bit unchanged. With no write and no event, pending holds its value.
- R4: When an event pulse and a clearing write to address 0 hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 replaces the whole enable register with write-data bits [3:0], and reading address 1 returns it.
- R6: A write to address 2 ORs write-data bits [3:0] into the pending register. Reading address 2 always returns zero.
- R7: Each output `irq_*` is high exactly when its pending bit and its enable bit are both one. It takes that value at the same clock edge that updates the registers, so it is visible in the cycle after the write or event.
- R8: Read-data bits [31:4] are always zero. Address 3 reads zero, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 4 | Single-cycle event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 pending, 1 enable, 2 test, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_tx_wm | output | 1 | TX watermark interrupt |
| irq_rx_wm | output | 1 | RX watermark interrupt |
| irq_tx_empty | output | 1 | TX empty interrupt |
| irq_rx_ovf | output | 1 | RX overflow interrupt |

## Verification
On every cycle, the assertions check how the pending bits move: an event always leaves its bit set, even against a clear; a clear with no competing event takes effect; a test write takes effect; and with no stimulus the register holds. They also check that the enable register loads exactly the written value, that the outputs equal pending AND enable, and that the upper read bits and the test address read zero. Only the bench's sweeps show that every one of the 256 pending/enable combinations reaches the right output pin. They also show that a partial clear leaves exactly the complement of its mask, and that a write to the unused address leaves both registers unchanged.

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    evt_in,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_tx_wm,
  output logic          irq_rx_wm,
  output logic          irq_tx_empty,
  output logic          irq_rx_ovf
);
  localparam int NSRC = 4;
  localparam logic [1:0] A_PEND = 2'd0, A_EN = 2'd1, A_TEST = 2'd2;

  logic [NSRC-1:0] pend_q, en_q, irq_q;
  logic [NSRC-1:0] clr_m, set_m, pend_d, en_d;
  logic [NSRC-1:0] rd_sel;

  assign clr_m  = (reg_wr && reg_addr == A_PEND) ? reg_wdata[NSRC-1:0] : '0;
  assign set_m  = (reg_wr && reg_addr == A_TEST) ? reg_wdata[NSRC-1:0] : '0;
  // events are merged last so they override a same-cycle clear
  assign pend_d = (pend_q & ~clr_m) | set_m | evt_in;
  assign en_d   = (reg_wr && reg_addr == A_EN) ? reg_wdata[NSRC-1:0] : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= pend_d & en_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_PEND:  rd_sel = pend_q;
      A_EN:    rd_sel = en_q;
      default: rd_sel = '0;
    endcase
  end

  assign reg_rdata    = {{(DW-NSRC){1'b0}}, rd_sel};
  assign irq_tx_wm    = irq_q[0];
  assign irq_rx_wm    = irq_q[1];
  assign irq_tx_empty = irq_q[2];
  assign irq_rx_ovf   = irq_q[3];

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((pend_q & $past(evt_in)) == $past(evt_in))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && evt_in == 4'd0) |=> ((pend_q & $past(reg_wdata[3:0])) == 4'd0)); // R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && evt_in == 4'd0) |=> $stable(pend_q)); // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && |evt_in) |=> ((pend_q & $past(evt_in)) == $past(evt_in))); // R4
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (en_q == $past(reg_wdata[3:0]))); // R5
  AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> ((pend_q & $past(reg_wdata[3:0])) == $past(reg_wdata[3:0]))); // R6
  AST_TEST_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata == '0)); // R6
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ({irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm} == (pend_q & en_q))); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DW-1:NSRC] == '0)); // R8
endmodule

// File: tb/irq_evt_bank_bench.sv
module irq_evt_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_in = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;

  int checks = 0;
  int failures = 0;
  logic [3:0] m_pend, m_en;

  always #4 clk = ~clk;

  irq_evt_bank u_irq_evt_bank (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] ev);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_in = ev;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    evt_in = ev;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] irqv();
    return {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 pending after reset", d, 0);
    rd(2'd1, d); chk("R1 enable after reset", d, 0);
    chk("R1 irq after reset", irqv(), 0);

    // R5 + R7: every enable with every pending pattern forced through test
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 16; s++) begin
        wr(2'd0, 32'hF, 4'd0);
        wr(2'd1, 32'hFFFF_FFF0 | e, 4'd0);
        wr(2'd2, s, 4'd0);
        chk("R7 irq equals pending and enable", irqv(), s & e);
        rd(2'd1, d); chk("R5 enable readback", d, e);
        rd(2'd2, d); chk("R6 test reads zero", d, 0);
        rd(2'd0, d); chk("R8 upper bits zero", d[31:4], 0);
      end
    end

    // R3 partial clear sweep
    wr(2'd1, 32'hF, 4'd0);
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, 32'hF, 4'd0);
      wr(2'd0, c, 4'd0);
      rd(2'd0, d); chk("R3 w1c leaves complement", d, 4'hF & ~c);
      chk("R7 irq after clear", irqv(), 4'hF & ~c);
      @(negedge clk);
      rd(2'd0, d); chk("R3 pending holds", d, 4'hF & ~c);
    end

    // R2 each event sets its own bit, R6 OR accumulates
    wr(2'd0, 32'hF, 4'd0);
    m_pend = '0;
    for (int b = 0; b < 4; b++) begin
      pulse(4'(1 << b));
      m_pend = m_pend | 4'(1 << b);
      rd(2'd0, d); chk("R2 event sets bit", d, m_pend);
      chk("R7 irq follows event", irqv(), m_pend);
    end
    wr(2'd0, 32'hF, 4'd0);
    wr(2'd2, 32'h5, 4'd0);
    wr(2'd2, 32'h2, 4'd0);
    rd(2'd0, d); chk("R6 test writes OR in", d, 4'h7);

    // R4 event beats same-cycle clear
    for (int b = 0; b < 4; b++) begin
      wr(2'd2, 32'hF, 4'd0);
      wr(2'd0, 32'hF, 4'(1 << b));
      rd(2'd0, d); chk("R4 event wins over clear", d, 32'(1 << b));
    end

    // R8 unused address
    wr(2'd0, 32'hF, 4'd0);
    wr(2'd2, 32'h9, 4'd0);
    wr(2'd1, 32'h6, 4'd0);
    wr(2'd3, 32'hFFFF_FFFF, 4'd0);
    rd(2'd0, d); chk("R8 addr3 write leaves pending", d, 4'h9);
    rd(2'd1, d); chk("R8 addr3 write leaves enable", d, 4'h6);
    rd(2'd3, d); chk("R8 addr3 reads zero", d, 0);
    chk("R8 irq unchanged", irqv(), 4'h0);

    // R1 reset again mid-run
    wr(2'd1, 32'hF, 4'd0);
    wr(2'd2, 32'hF, 4'd0);
    rst_n = 1'b0;
    #1 chk("R1 irq cleared by reset", irqv(), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(2'd0, d); chk("R1 pending cleared by reset", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule